// File: doc/BRIEF.md
# Multi-Pattern PRBS Test Generator

A serial maintenance pattern source that produces one bit for every clock on which the bit-enable strobe is high. Software picks one of four pseudorandom sequences with a 2-bit select. Three of them are plain maximal-length sequences. The fourth is a quasi-random sequence whose zero runs are cut short.

The stream can go out unframed. It can also carry framing bits laid over it in either of two ways. In the first, one framing bit precedes each block of payload bits and walks a 12-frame superframe pattern. In the second, an 8-bit slot at the head of each 256-bit frame carries an alignment word and a non-alignment word, one after the other. The pseudorandom register holds still during framing bits.

A single output bit can be inverted on demand to test downstream error detection. Only a rising edge of the control does this; holding the control high does nothing more.

Top module: `prbs_pattern_tx`

## Requirements
- R1: While `rst_ni` is low, `data_o` is 0. The generator register is seeded with all ones, and the framing position is set to the first bit of frame 0 of the superframe.
- R2: `data_o` changes only at a rising clock edge where `bit_en_i` is 1. The `pat_sel_i` encoding is 00 = 2^15-1, 01 = 2^20-1, 10 = 2^23-1 and 11 = quasi-random. Each generated bit b[n] equals b[n-L] xor b[n-T], with (L,T) = (15,14), (20,3), (23,18) and (20,17) for these codes. The bits before the first generated bit count as ones. So with code 01, the first four bits after reset are 0,0,0,1.
- R3: For codes 00 and 10, the emitted bit is the inverse of the generated bit. So with code 00, the first fifteen bits after reset are fourteen ones and then a zero.
- R4: For code 11, a zero that would make a run of more than ZERO_LIMIT consecutive zero payload bits (default 14) is sent as a one, and the zero run restarts. The generator register still advances as usual.
- R5: A cycle with `bit_en_i` low leaves `data_o`, the generator register, the framing position and the zero run unchanged.
- R6: With `framed_i`=1 and `ds1_sel_i`=1, each frame is 193 bits long. Bit 0 is a framing bit and is followed by 192 payload bits. The framing bit of superframe frame k (k = 0..11) is bit k of 100011011100, read from the left.
- R7: With `framed_i`=1 and `ds1_sel_i`=0, each frame is 256 bits long. Bits 0-7 carry 10011011 in even frames and 11011111 in odd frames, leftmost bit first. The other 248 bits are payload.
- R8: A rising edge of `err_ins_i` inverts exactly one bit: the next bit sent with `bit_en_i` high. This includes a bit sent in the same cycle as the edge. A level held high has no further effect.
- R9: The first payload bit sent after `pat_sel_i` changes is computed from the all-ones seed. The new sequence therefore starts from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Emit one bit this cycle |
| pat_sel_i | input | 2 | Sequence select |
| framed_i | input | 1 | 1 = overlay framing bits |
| ds1_sel_i | input | 1 | 1 = 193-bit superframe framing, 0 = 256-bit frame framing |
| err_ins_i | input | 1 | Rising edge inverts one output bit |
| data_o | output | 1 | Serial test pattern |

## Verification
A corrupted generator register, whether from a lost seed, a wrong tap or a missed reload, breaks the recurrence. The mismatch reaches `data_o` within at most 23 enabled bits, so every run is compared bit by bit against an independent recurrence model. A drifted framing counter first shows up on the next framing bit, which may be up to one frame away. Runs of several full frames and a whole superframe catch it. A zero-run counter fault can stay hidden for thousands of bits at the default limit. A second instance with a limit of 3 is therefore compared against the raw sequence, and there forced ones appear within tens of bits.

// File: rtl/prbs_tx_pkg.sv
package prbs_tx_pkg;
  localparam int unsigned LFSR_W = 23;
  localparam int unsigned NPAT   = 4;

  typedef enum logic [1:0] {
    PAT_P15  = 2'b00,
    PAT_P20  = 2'b01,
    PAT_P23  = 2'b10,
    PAT_QRSS = 2'b11
  } pat_e;

  function automatic int unsigned pat_len(pat_e p);
    case (p)
      PAT_P15: return 15;
      PAT_P23: return 23;
      default: return 20;
    endcase
  endfunction

  function automatic int unsigned pat_tap(pat_e p);
    case (p)
      PAT_P15: return 14;
      PAT_P20: return 3;
      PAT_P23: return 18;
      default: return 17;
    endcase
  endfunction

  function automatic logic pat_inv(pat_e p);
    return (p == PAT_P15) || (p == PAT_P23);
  endfunction

  function automatic logic [LFSR_W-1:0] pat_mask(pat_e p);
    return (LFSR_W'(1) << pat_len(p)) - LFSR_W'(1);
  endfunction
endpackage

// File: rtl/prbs_core.sv
module prbs_core
  import prbs_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  pat_e sel_i,
  output logic bit_o
);
  logic [LFSR_W-1:0] state_q, cur;
  pat_e              last_q;
  logic              reload;
  logic [NPAT-1:0]   fb_vec;

  assign reload = (sel_i != last_q);
  assign cur    = reload ? '1 : state_q;

  for (genvar g = 0; g < NPAT; g++) begin : g_pat
    localparam int unsigned L = pat_len(pat_e'(g));
    localparam int unsigned T = pat_tap(pat_e'(g));
    assign fb_vec[g] = cur[L-1] ^ cur[T-1];
  end

  assign bit_o = fb_vec[sel_i] ^ pat_inv(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '1;
      last_q  <= PAT_P15;
    end else if (step_i) begin
      state_q <= {cur[LFSR_W-2:0], fb_vec[sel_i]};
      last_q  <= sel_i;
    end
  end

  // R2: active window never collapses to the lock-up state
  a_r2_state_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q & pat_mask(last_q)) != '0);
endmodule

// File: rtl/zero_run_limit.sv
module zero_run_limit #(
  parameter int unsigned LIMIT = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic active_i,
  input  logic bit_i,
  output logic bit_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign bit_o = bit_i | (active_i & (cnt_q == CW'(LIMIT)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (!active_i)  cnt_q <= '0;
    else if (step_i)     cnt_q <= bit_o ? '0 : cnt_q + 1'b1;
  end

  a_r4_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl #(
  parameter int unsigned DS1_PAYLOAD = 192,
  parameter int unsigned E1_FRAME    = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic framed_i,
  input  logic ds1_i,
  output logic is_fbit_o,
  output logic fbit_o
);
  localparam int unsigned DS1_LEN   = DS1_PAYLOAD + 1;
  localparam int unsigned MAXLEN    = (DS1_LEN > E1_FRAME) ? DS1_LEN : E1_FRAME;
  localparam int unsigned PW        = $clog2(MAXLEN + 1);
  localparam int unsigned SF_FRAMES = 12;
  localparam int unsigned FW        = $clog2(SF_FRAMES);
  localparam int unsigned TS0_BITS  = 8;
  localparam logic [SF_FRAMES-1:0] SF_PAT  = 12'b100011011100;
  localparam logic [TS0_BITS-1:0]  W_ALIGN = 8'b10011011;
  localparam logic [TS0_BITS-1:0]  W_NALGN = 8'b11011111;
  localparam logic [FW-1:0]        LASTF   = FW'(SF_FRAMES - 1);

  logic [PW-1:0] pos_q, last_pos;
  logic [FW-1:0] fr_q;
  logic          wrap;
  logic [TS0_BITS-1:0] ts0_word;

  assign last_pos = ds1_i ? PW'(DS1_LEN - 1) : PW'(E1_FRAME - 1);
  assign wrap     = (pos_q >= last_pos);
  assign ts0_word = fr_q[0] ? W_NALGN : W_ALIGN;

  assign is_fbit_o = framed_i & (ds1_i ? (pos_q == '0) : (pos_q < PW'(TS0_BITS)));
  assign fbit_o    = ds1_i ? SF_PAT[LASTF - fr_q] : ts0_word[3'd7 - pos_q[2:0]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      fr_q  <= '0;
    end else if (step_i) begin
      pos_q <= wrap ? '0 : pos_q + 1'b1;
      if (wrap) fr_q <= (fr_q == LASTF) ? '0 : fr_q + 1'b1;
    end
  end

  a_r6_pos_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < PW'(MAXLEN));
  a_r6_sf_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_q <= LASTF);
  a_r5_pos_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q) && $stable(fr_q));
endmodule

// File: rtl/prbs_pattern_tx.sv
module prbs_pattern_tx
  import prbs_tx_pkg::*;
#(
  parameter int unsigned DS1_PAYLOAD = 192,
  parameter int unsigned E1_FRAME    = 256,
  parameter int unsigned ZERO_LIMIT  = 14
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_en_i,
  input  logic [1:0] pat_sel_i,
  input  logic       framed_i,
  input  logic       ds1_sel_i,
  input  logic       err_ins_i,
  output logic       data_o
);
  pat_e sel;
  logic is_fbit, fbit, prbs_bit, lim_bit, pay_step;
  logic err_q, pend_q, rise, flip;

  assign sel      = pat_e'(pat_sel_i);
  assign pay_step = bit_en_i & ~is_fbit;
  assign rise     = err_ins_i & ~err_q;
  assign flip     = pend_q | rise;

  prbs_core u_core (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(pay_step),
    .sel_i (sel),
    .bit_o (prbs_bit)
  );

  zero_run_limit #(.LIMIT(ZERO_LIMIT)) u_lim (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (pay_step),
    .active_i(sel == PAT_QRSS),
    .bit_i   (prbs_bit),
    .bit_o   (lim_bit)
  );

  frame_ctrl #(.DS1_PAYLOAD(DS1_PAYLOAD), .E1_FRAME(E1_FRAME)) u_frm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (bit_en_i),
    .framed_i (framed_i),
    .ds1_i    (ds1_sel_i),
    .is_fbit_o(is_fbit),
    .fbit_o   (fbit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      data_o <= 1'b0;
    end else begin
      err_q <= err_ins_i;
      if (bit_en_i) begin
        data_o <= (is_fbit ? fbit : lim_bit) ^ flip;
        pend_q <= 1'b0;
      end else begin
        pend_q <= flip;
      end
    end
  end

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(data_o));
  a_r8_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i |=> !pend_q);
  a_r8_level_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && err_ins_i && !pend_q) |=> !pend_q);
endmodule

// File: tb/sim_prbs_pattern_tx.sv
module sim_prbs_pattern_tx;
  typedef struct packed {
    logic [1:0]  sel;
    logic        fr;
    logic        ds1;
    logic [15:0] n;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 1'b0, 1'b0, 16'd300},
    '{2'b01, 1'b0, 1'b0, 16'd300},
    '{2'b10, 1'b0, 1'b0, 16'd300},
    '{2'b11, 1'b0, 1'b0, 16'd4000},
    '{2'b00, 1'b1, 1'b1, 16'd2336},
    '{2'b01, 1'b1, 1'b0, 16'd532},
    '{2'b11, 1'b1, 1'b1, 16'd500},
    '{2'b10, 1'b1, 1'b0, 16'd600}
  };
  localparam logic [11:0] SF  = 12'b100011011100;
  localparam logic [7:0]  FAS = 8'b10011011;
  localparam logic [7:0]  NFA = 8'b11011111;

  logic clk = 1'b0;
  logic rst_n, bit_en, framed, ds1, err;
  logic [1:0] sel;
  logic d0, d1;

  always #4 clk = ~clk;

  prbs_pattern_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .pat_sel_i(sel),
    .framed_i(framed), .ds1_sel_i(ds1), .err_ins_i(err), .data_o(d0));

  prbs_pattern_tx #(.ZERO_LIMIT(3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .pat_sel_i(sel),
    .framed_i(framed), .ds1_sel_i(ds1), .err_ins_i(err), .data_o(d1));

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [22:0] m_s;
  logic [1:0]  m_last;
  int          m_zc, m_pos, m_fr, z1, forced;
  logic        m_raw, m_pend;

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_bit(output logic e);
    logic is_f;
    logic [22:0] cur;
    logic [7:0] w;
    logic fb;
    int L, T;
    is_f  = framed && (ds1 ? (m_pos == 0) : (m_pos < 8));
    m_raw = 1'b0;
    if (is_f) begin
      w = (m_fr % 2) ? NFA : FAS;
      e = ds1 ? SF[11 - m_fr] : w[7 - m_pos];
    end else begin
      case (sel)
        2'b00: begin L = 15; T = 14; end
        2'b01: begin L = 20; T = 3;  end
        2'b10: begin L = 23; T = 18; end
        default: begin L = 20; T = 17; end
      endcase
      cur    = (sel != m_last) ? '1 : m_s;
      fb     = cur[L-1] ^ cur[T-1];
      m_s    = {cur[21:0], fb};
      m_last = sel;
      m_raw  = fb ^ ((sel == 2'b00) || (sel == 2'b10));
      if (sel == 2'b11) begin
        e    = (!m_raw && m_zc == 14) ? 1'b1 : m_raw;
        m_zc = e ? 0 : m_zc + 1;
      end else begin
        e    = m_raw;
        m_zc = 0;
      end
    end
    if (m_pos >= (ds1 ? 192 : 255)) begin
      m_pos = 0;
      m_fr  = (m_fr + 1) % 12;
    end else m_pos++;
    if (m_pend) begin
      e = ~e;
      m_pend = 1'b0;
    end
  endtask

  task automatic do_reset(logic [1:0] s, logic f, logic d);
    rst_n = 1'b0; bit_en = 1'b0; err = 1'b0;
    sel = s; framed = f; ds1 = d;
    m_s = '1; m_last = 2'b00; m_zc = 0; m_pos = 0; m_fr = 0; m_pend = 1'b0; z1 = 0;
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset output", d0, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic run_bits(int n, string req);
    logic e;
    bit_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      model_bit(e);
      check(req, d0, e);
    end
    bit_en = 1'b0;
  endtask

  task automatic lit_bits(logic [31:0] pat, int n, string req);
    logic e;
    bit_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      model_bit(e);
      check(req, d0, pat[n-1-i]);
    end
    bit_en = 1'b0;
  endtask

  task automatic idle(int n, string req);
    logic v;
    v = d0;
    bit_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      check(req, d0, v);
    end
  endtask

  task automatic set_err(logic v);
    if (v && !err) m_pend = 1'b1;
    err = v;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic string tag_of(vec_t v);
    if (v.fr) return v.ds1 ? "R6 superframe" : "R7 frame word";
    if (v.sel == 2'b11) return "R4 quasi-random";
    if (v.sel == 2'b01) return "R2 sequence";
    return "R3 inverted sequence";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: got timeout expected completion");
      done = 1'b1;
      summary();
    end
  end

  initial begin
    logic e, e1;
    // vector table
    for (int k = 0; k < NVEC; k++) begin
      do_reset(VECS[k].sel, VECS[k].fr, VECS[k].ds1);
      run_bits(int'(VECS[k].n), tag_of(VECS[k]));
    end

    // R1/R2: first bits of 2^20-1 from seed
    do_reset(2'b01, 1'b0, 1'b0);
    lit_bits(32'b0001, 4, "R2 first bits");
    // R3: fourteen ones then zero
    do_reset(2'b00, 1'b0, 1'b0);
    lit_bits(32'b111111111111110, 15, "R3 first bits");
    // R6/R7 first framing bits
    do_reset(2'b00, 1'b1, 1'b1);
    lit_bits(32'b1, 1, "R6 first framing bit");
    do_reset(2'b10, 1'b1, 1'b0);
    lit_bits(32'b10011011, 8, "R7 alignment word");
    run_bits(248, "R7 payload");
    lit_bits(32'b11011111, 8, "R7 non-alignment word");

    // R5: idle holds everything
    do_reset(2'b10, 1'b1, 1'b1);
    run_bits(50, "R5 pre");
    idle(6, "R5 hold");
    run_bits(400, "R5 resume");

    // R8: error insertion
    do_reset(2'b00, 1'b0, 1'b0);
    run_bits(10, "R8 pre");
    set_err(1'b1);
    run_bits(1, "R8 flip same cycle");
    run_bits(20, "R8 level held");
    set_err(1'b0);
    idle(2, "R8 idle");
    set_err(1'b1);
    idle(3, "R8 pending idle");
    set_err(1'b0);
    run_bits(5, "R8 flip after idle");
    set_err(1'b1);
    idle(1, "R8 idle2");
    run_bits(5, "R8 flip next");
    set_err(1'b0);

    // R9: pattern change reloads seed
    do_reset(2'b00, 1'b0, 1'b0);
    run_bits(37, "R9 pre");
    sel = 2'b01;
    lit_bits(32'b0001, 4, "R9 reload");
    run_bits(50, "R9 after");
    sel = 2'b10;
    run_bits(60, "R9 second change");

    // R4: limiter exercised on instance with limit 3
    do_reset(2'b11, 1'b0, 1'b0);
    forced = 0;
    bit_en = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk); #2;
      model_bit(e);
      check("R4 limit 14", d0, e);
      e1 = m_raw | (z1 == 3);
      if (!m_raw && z1 == 3) forced++;
      z1 = e1 ? 0 : z1 + 1;
      check("R4 limit 3", d1, e1);
    end
    bit_en = 1'b0;
    n_chk++;
    if (forced == 0) begin
      n_bad++;
      $display("FAIL R4 forced ones: got %0d expected >0", forced);
    end

    done = 1'b1;
    summary();
  end
endmodule